// File: doc/BRIEF.md
# ALU with sticky carry and condition select

This block is the arithmetic/logic stage of a 32-bit execution datapath. Each cycle it takes a left operand, a right operand, a 5-bit operation code and a 4-bit condition select. It produces a combinational result and one condition bit, which the fetch logic uses to decide on a jump or trap. The sum is built from per-bit propagate and kill terms. Add, subtract and the three logical functions differ only in how those terms come from the operands.

A one-bit carry register sits beside the datapath. The opcode decides where carry-in comes from: the stored carry, a constant 0 or a constant 1. It also decides what is written back: 0, carry-out, inverted carry-out, or nothing. The register is frozen while the reject strobe is high. It is also frozen whenever the selected condition is true, so an instruction that redirects the flow leaves no carry trace.

Bit numbering: the most significant bit is vector index 31 and the next one is index 30. Everywhere below, "top bit" means index 31.

Top module: `alu_sticky_carry`

## Requirements
- R1: After reset (rst_ni low) the stored carry is 0. An opcode 4 with both operands 0 then yields result 0.
- R2: Opcodes 2, 4, 6, 12 and 14 yield a + b + cin modulo 2^32. cin is 0 for 2, 6 and 12, and cin is the stored carry for 4 and 14.
- R3: Opcodes 3, 5, 7, 13 and 15 yield a + ~b + cin modulo 2^32. cin is 1 for 3, 7 and 13, and cin is the stored carry for 5 and 15.
- R4: The logical opcodes yield a | b for 0, a & b for 1 and a ^ b for 8.
- R5: Opcodes 9 and 10 yield a zero result and a carry-out of 0.
- R6: When an update is allowed, the next carry is as follows. It is 0 for opcodes 4, 5, 6 and 7. It is the inverted carry-out for 15. It is the carry-out for 0, 1, 2, 3, 8, 9, 10, 12, 13 and 14. Logical and zero-result opcodes have carry-out 0.
- R7: While reject_i is 1 at a clock edge, the stored carry does not change.
- R8: When cond_o is 1 at a clock edge, the stored carry does not change.
- R9: Opcode 11 and opcodes 16 to 31 yield a | b and never change the stored carry.
- R10: The condition selects are as follows, with z meaning the result is zero and n meaning the result's top bit:
  - 0 gives 0 and 4 gives 1.
  - 1 gives z and 5 gives its complement.
  - 2 gives n and 6 gives its complement.
  - 3 gives n|z and 7 gives its complement.
- R11: Select 8 gives overflow and 12 gives its complement. Overflow is the carry into the top bit XOR the carry out of the top bit.
- R12: Select 9 gives (a top bit) OR (result top bit is 0), and 13 gives its complement.
- R13: Select 10 is 1 when bits 31 and 30 differ in a, or in b, or in the result. Select 14 gives its complement.
- R14: Select 15 is 1 when result bits 31..24 are all zero, and select 11 gives its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the carry |
| opl_i | input | 32 | Left operand |
| opr_i | input | 32 | Right operand |
| op_i | input | 5 | Operation code |
| cond_sel_i | input | 4 | Condition select |
| reject_i | input | 1 | Reject strobe; freezes the carry |
| result_o | output | 32 | Combinational result |
| cond_o | output | 1 | Selected condition bit |

## Verification
Some rules are checked on every cycle by the assertions:
- the carry freezes under reject, under a true condition and under spare opcodes;
- the four clearing opcodes leave the carry at 0;
- the field opcodes give a zero result;
- selects 0 and 4 give fixed values.

Other behaviour shows only in the bench's scenarios:
- the arithmetic values;
- the carry-in source for each opcode, observed through a following stored-carry add;
- the overflow, bounds, tag and top-byte conditions.

The bench compares all of these against its own 33-bit arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W  = 5;
  localparam int unsigned SEL_W = 4;

  localparam logic [OP_W-1:0] OP_OR    = 5'd0;
  localparam logic [OP_W-1:0] OP_AND   = 5'd1;
  localparam logic [OP_W-1:0] OP_VADD2 = 5'd2;
  localparam logic [OP_W-1:0] OP_BND   = 5'd3;
  localparam logic [OP_W-1:0] OP_SADD  = 5'd4;
  localparam logic [OP_W-1:0] OP_SSUB  = 5'd5;
  localparam logic [OP_W-1:0] OP_LADD  = 5'd6;
  localparam logic [OP_W-1:0] OP_LSUB  = 5'd7;
  localparam logic [OP_W-1:0] OP_XOR   = 5'd8;
  localparam logic [OP_W-1:0] OP_FLD   = 5'd9;
  localparam logic [OP_W-1:0] OP_FLDK  = 5'd10;
  localparam logic [OP_W-1:0] OP_VADD  = 5'd12;
  localparam logic [OP_W-1:0] OP_VSUB  = 5'd13;
  localparam logic [OP_W-1:0] OP_UADD  = 5'd14;
  localparam logic [OP_W-1:0] OP_USUB  = 5'd15;

  typedef enum logic [2:0] {FN_OR, FN_AND, FN_XOR, FN_ADD, FN_SUB, FN_ZERO} fn_e;
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_STORED} cin_e;
  typedef enum logic [1:0] {CO_ZERO, CO_PASS, CO_INV, CO_HOLD} co_e;

  typedef struct packed {
    fn_e  fn;
    cin_e cin;
    co_e  co;
  } ctl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);
  always_comb begin
    ctl_o = '{fn: FN_OR, cin: CIN_ZERO, co: CO_HOLD};
    unique case (op_i)
      OP_OR:    ctl_o = '{fn: FN_OR,   cin: CIN_ZERO,   co: CO_PASS};
      OP_AND:   ctl_o = '{fn: FN_AND,  cin: CIN_ZERO,   co: CO_PASS};
      OP_XOR:   ctl_o = '{fn: FN_XOR,  cin: CIN_ZERO,   co: CO_PASS};
      OP_VADD2: ctl_o = '{fn: FN_ADD,  cin: CIN_ZERO,   co: CO_PASS};
      OP_VADD:  ctl_o = '{fn: FN_ADD,  cin: CIN_ZERO,   co: CO_PASS};
      OP_LADD:  ctl_o = '{fn: FN_ADD,  cin: CIN_ZERO,   co: CO_ZERO};
      OP_SADD:  ctl_o = '{fn: FN_ADD,  cin: CIN_STORED, co: CO_ZERO};
      OP_UADD:  ctl_o = '{fn: FN_ADD,  cin: CIN_STORED, co: CO_PASS};
      OP_BND:   ctl_o = '{fn: FN_SUB,  cin: CIN_ONE,    co: CO_PASS};
      OP_VSUB:  ctl_o = '{fn: FN_SUB,  cin: CIN_ONE,    co: CO_PASS};
      OP_LSUB:  ctl_o = '{fn: FN_SUB,  cin: CIN_ONE,    co: CO_ZERO};
      OP_SSUB:  ctl_o = '{fn: FN_SUB,  cin: CIN_STORED, co: CO_ZERO};
      OP_USUB:  ctl_o = '{fn: FN_SUB,  cin: CIN_STORED, co: CO_INV};
      OP_FLD:   ctl_o = '{fn: FN_ZERO, cin: CIN_ZERO,   co: CO_PASS};
      OP_FLDK:  ctl_o = '{fn: FN_ZERO, cin: CIN_ZERO,   co: CO_PASS};
      default:  ctl_o = '{fn: FN_OR,   cin: CIN_ZERO,   co: CO_HOLD};
    endcase
  end
endmodule

// File: rtl/alu_pk_core.sv
module alu_pk_core
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fn_e          fn_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_top_in_o,
  output logic         cout_o
);
  logic [W-1:0] prop, kill;

  // kill forced high for non-arithmetic functions, so carries never travel
  always_comb begin
    unique case (fn_i)
      FN_ADD:  begin prop = a_i ^ b_i;    kill = ~a_i & ~b_i; end
      FN_SUB:  begin prop = ~(a_i ^ b_i); kill = ~a_i & b_i;  end
      FN_XOR:  begin prop = a_i ^ b_i;    kill = '1;          end
      FN_AND:  begin prop = a_i & b_i;    kill = '1;          end
      FN_OR:   begin prop = a_i | b_i;    kill = '1;          end
      default: begin prop = '0;           kill = '1;          end
    endcase
  end

  always_comb begin
    logic c;
    c          = cin_i;
    c_top_in_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      sum_o[i] = prop[i] ^ c;
      if (i == W-1) c_top_in_o = c;
      c = prop[i] ? c : ~kill[i];
    end
    cout_o = c;
  end
endmodule

// File: rtl/alu_cond_sel.sv
module alu_cond_sel
  import alu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned KW = 8
) (
  input  logic [W-1:0]     res_i,
  input  logic [1:0]       l_top_i,
  input  logic [1:0]       r_top_i,
  input  logic             c_top_in_i,
  input  logic             cout_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             cond_o
);
  localparam int unsigned KLO = W - KW;

  logic is_zero, is_neg, is_le, ovf, bnd, tag_bad, k_zero;
  logic [3:0] base_lo, base_hi;

  assign is_zero = (res_i == '0);
  assign is_neg  = res_i[W-1];
  assign is_le   = is_neg | is_zero;
  assign ovf     = c_top_in_i ^ cout_i;
  assign bnd     = l_top_i[1] | ~is_neg;
  assign tag_bad = (l_top_i[1] ^ l_top_i[0]) | (r_top_i[1] ^ r_top_i[0]) |
                   (res_i[W-1] ^ res_i[W-2]);
  assign k_zero  = (res_i[W-1:KLO] == '0);

  // selects pair up as x / x^4; select 11 is the complement of 15
  assign base_lo = {is_le, is_neg, is_zero, 1'b0};
  assign base_hi = {~k_zero, tag_bad, bnd, ovf};
  assign cond_o  = (sel_i[3] ? base_hi[sel_i[1:0]] : base_lo[sel_i[1:0]]) ^ sel_i[2];
endmodule

// File: rtl/alu_sticky_carry.sv
module alu_sticky_carry
  import alu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned KW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     opl_i,
  input  logic [W-1:0]     opr_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [SEL_W-1:0] cond_sel_i,
  input  logic             reject_i,
  output logic [W-1:0]     result_o,
  output logic             cond_o
);
  ctl_t ctl;
  logic carry_q, carry_d, cin, cout, c_top_in, upd_en;

  alu_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  always_comb begin
    unique case (ctl.cin)
      CIN_ONE:    cin = 1'b1;
      CIN_STORED: cin = carry_q;
      default:    cin = 1'b0;
    endcase
  end

  alu_pk_core #(.W(W)) u_core (
    .a_i(opl_i), .b_i(opr_i), .fn_i(ctl.fn), .cin_i(cin),
    .sum_o(result_o), .c_top_in_o(c_top_in), .cout_o(cout)
  );

  alu_cond_sel #(.W(W), .KW(KW)) u_cond (
    .res_i(result_o), .l_top_i(opl_i[W-1:W-2]), .r_top_i(opr_i[W-1:W-2]),
    .c_top_in_i(c_top_in), .cout_i(cout), .sel_i(cond_sel_i), .cond_o(cond_o)
  );

  always_comb begin
    unique case (ctl.co)
      CO_PASS: carry_d = cout;
      CO_INV:  carry_d = ~cout;
      CO_ZERO: carry_d = 1'b0;
      default: carry_d = carry_q;
    endcase
  end

  // a redirecting or rejected instruction leaves no carry trace
  assign upd_en = ~reject_i & ~cond_o & (ctl.co != CO_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     carry_q <= 1'b0;
    else if (upd_en) carry_q <= carry_d;
  end

  a_r7_reject_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_i |=> carry_q == $past(carry_q));

  a_r8_cond_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_o |=> carry_q == $past(carry_q));

  a_r9_spare_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 5'd11 || op_i >= 5'd16) |=> carry_q == $past(carry_q));

  a_r6_clear_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reject_i && !cond_o && op_i >= OP_SADD && op_i <= OP_LSUB) |=> !carry_q);

  a_r5_field_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FLD || op_i == OP_FLDK) |-> result_o == '0);

  a_r10_fixed_selects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == 4'd0 |-> !cond_o) and (cond_sel_i == 4'd4 |-> cond_o));
endmodule

// File: tb/alu_sticky_carry_tb_top.sv
`timescale 1ns/1ps
module alu_sticky_carry_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opl = '0, opr = '0;
  logic [4:0]  op = '0;
  logic [3:0]  sel = '0;
  logic        rej = 1'b0;
  logic [31:0] result;
  logic        cond;

  int checks = 0;
  int errors = 0;
  bit m_carry = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic        c;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  alu_sticky_carry dut_i (
    .clk_i(clk), .rst_ni(rst_n), .opl_i(opl), .opr_i(opr), .op_i(op),
    .cond_sel_i(sel), .reject_i(rej), .result_o(result), .cond_o(cond)
  );

  task automatic model(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] s, input bit rj,
                       output logic [31:0] r, output logic cn);
    logic [31:0] bb, lo;
    logic [32:0] t;
    bit arith, ci, co, cm, z, n, le, ov, bc, il, kz;
    arith = (o inside {5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd14, 5'd15});
    bb = (o inside {5'd3, 5'd5, 5'd7, 5'd13, 5'd15}) ? ~b : b;
    if (o inside {5'd4, 5'd5, 5'd14, 5'd15}) ci = m_carry;
    else if (o inside {5'd3, 5'd7, 5'd13})   ci = 1'b1;
    else                                     ci = 1'b0;
    if (arith) begin
      t  = {1'b0, a} + {1'b0, bb} + {32'd0, ci};
      lo = {1'b0, a[30:0]} + {1'b0, bb[30:0]} + {31'd0, ci};
      r  = t[31:0]; co = t[32]; cm = lo[31];
    end else begin
      co = 1'b0; cm = 1'b0;
      if (o == 5'd1)                     r = a & b;
      else if (o == 5'd8)                r = a ^ b;
      else if (o == 5'd9 || o == 5'd10)  r = '0;
      else                               r = a | b;
    end
    z = (r == 0); n = r[31]; le = n | z; ov = cm ^ co;
    bc = a[31] | ~n;
    il = (a[31] ^ a[30]) | (b[31] ^ b[30]) | (r[31] ^ r[30]);
    kz = (r[31:24] == 0);
    case (s)
      4'd0: cn = 0;     4'd1: cn = z;     4'd2: cn = n;      4'd3: cn = le;
      4'd4: cn = 1;     4'd5: cn = ~z;    4'd6: cn = ~n;     4'd7: cn = ~le;
      4'd8: cn = ov;    4'd9: cn = bc;    4'd10: cn = il;    4'd11: cn = ~kz;
      4'd12: cn = ~ov;  4'd13: cn = ~bc;  4'd14: cn = ~il;   default: cn = kz;
    endcase
    if (!rj && !cn) begin
      if (o inside {5'd4, 5'd5, 5'd6, 5'd7}) m_carry = 1'b0;
      else if (o == 5'd15)                   m_carry = ~co;
      else if (o == 5'd11 || o >= 5'd16)     m_carry = m_carry;
      else                                   m_carry = co;
    end
  endtask

  task automatic drive(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] s, input bit rj, input string tag);
    exp_t e;
    @(negedge clk);
    op = o; opl = a; opr = b; sel = s; rej = rj;
    e.tag = tag;
    model(o, a, b, s, rj, e.r, e.c);
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result !== e.r) begin
        errors++;
        $display("FAIL %s result actual %h expected %h", e.tag, result, e.r);
      end
      checks++;
      if (cond !== e.c) begin
        errors++;
        $display("FAIL %s cond actual %b expected %b", e.tag, cond, e.c);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog for all requirements actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(5'd4, 32'h0, 32'h0, 4'd0, 0, "R1 reset carry");
    // stored carry set by wrap, then consumed by add-with-carry
    drive(5'd14, 32'hffff_ffff, 32'h1, 4'd0, 0, "R2 uadd wrap");
    drive(5'd4, 32'd5, 32'd6, 4'd0, 0, "R2 sadd cin");
    drive(5'd4, 32'h0, 32'h0, 4'd0, 0, "R6 sadd clears");
    drive(5'd2, 32'h1234_5678, 32'h0fed_cba9, 4'd0, 0, "R2 vadd2");
    drive(5'd6, 32'h8000_0000, 32'h8000_0000, 4'd1, 0, "R2 ladd");
    drive(5'd12, 32'h7fff_ffff, 32'h1, 4'd8, 0, "R11 overflow");
    drive(5'd12, 32'h7fff_fffe, 32'h1, 4'd12, 0, "R11 no overflow");
    drive(5'd13, 32'd10, 32'd3, 4'd0, 0, "R3 vsub");
    drive(5'd5, 32'd10, 32'd3, 4'd0, 0, "R3 ssub cin1");
    drive(5'd5, 32'd10, 32'd3, 4'd0, 0, "R3 ssub cin0");
    drive(5'd7, 32'd3, 32'd5, 4'd2, 0, "R3 lsub");
    drive(5'd3, 32'h8000_0000, 32'd1, 4'd9, 0, "R12 bndchk");
    drive(5'd3, 32'd1, 32'd2, 4'd13, 0, "R12 bndchk low");
    drive(5'd15, 32'd3, 32'd5, 4'd0, 0, "R6 usub borrow");
    drive(5'd4, 32'h0, 32'h0, 4'd0, 0, "R6 usub stored inverse");
    drive(5'd0, 32'hf0f0_0000, 32'h0f0f_0001, 4'd0, 0, "R4 or");
    drive(5'd1, 32'hff00_ff00, 32'h0ff0_0ff0, 4'd0, 0, "R4 and");
    drive(5'd8, 32'haaaa_5555, 32'hffff_0000, 4'd0, 0, "R4 xor");
    drive(5'd14, 32'hffff_ffff, 32'h1, 4'd0, 0, "R6 set carry");
    drive(5'd9, 32'hdead_beef, 32'h1234_5678, 4'd1, 0, "R5 fop");
    drive(5'd14, 32'hffff_ffff, 32'h1, 4'd0, 0, "R6 set carry");
    drive(5'd10, 32'hdead_beef, 32'h1234_5678, 4'd0, 0, "R5 fopk");
    drive(5'd4, 32'h0, 32'h0, 4'd0, 0, "R5 field carry out");
    // freeze under reject
    drive(5'd14, 32'hffff_ffff, 32'h1, 4'd0, 0, "R7 set carry");
    drive(5'd14, 32'd1, 32'd1, 4'd0, 1, "R7 rejected");
    drive(5'd4, 32'h0, 32'h0, 4'd0, 0, "R7 carry held");
    // freeze under true condition
    drive(5'd14, 32'hffff_ffff, 32'h1, 4'd0, 0, "R8 set carry");
    drive(5'd14, 32'd1, 32'd1, 4'd4, 0, "R8 cond true");
    drive(5'd4, 32'h0, 32'h0, 4'd0, 0, "R8 carry held");
    // spare opcodes
    drive(5'd14, 32'hffff_ffff, 32'h1, 4'd0, 0, "R9 set carry");
    drive(5'd11, 32'h00f0_0000, 32'h0000_000f, 4'd0, 0, "R9 op11");
    drive(5'd20, 32'h1, 32'h2, 4'd0, 0, "R9 op20");
    drive(5'd31, 32'h8000_0000, 32'h0, 4'd0, 0, "R9 op31");
    drive(5'd14, 32'h0, 32'h0, 4'd0, 0, "R9 carry held");
    // condition sweep
    for (int s = 0; s < 16; s++) begin
      drive(5'd12, 32'h7fff_ffff, 32'h1, s[3:0], 0, "R10 R11 sweep ovf");
      drive(5'd0, 32'h0, 32'h0, s[3:0], 0, "R10 R14 sweep zero");
      drive(5'd8, 32'h4000_0000, 32'hc000_0001, s[3:0], 0, "R13 sweep tag");
      drive(5'd13, 32'h0000_0005, 32'h0000_0007, s[3:0], 0, "R12 sweep neg");
      drive(5'd1, 32'h00ff_ffff, 32'h00ff_0f0f, s[3:0], 0, "R14 sweep kernel");
    end
    drive(5'd8, 32'h0, 32'h4000_0000, 4'd10, 0, "R13 right tag");
    drive(5'd0, 32'h0100_0000, 32'h0, 4'd15, 0, "R14 kernel miss");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule